// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Loadable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. The write side and the read side each have their own clock. The two clocks may be the same net, or they may run with no fixed relation to each other. The storage is an inferred RAM whose depth is a power of two, set by a parameter. The read side drives the stored word from a register, and an output-enable input can release that register's drivers to high impedance.

Each side is qualified by a pair of enables, one active low and one active high. A single enable can therefore be used by tying the other to its active level. The buffer reports Empty and Almost-Empty to the read side, and Full and Almost-Full to the write side.

The two almost thresholds come from a pair of offset registers. Both offsets default to 7. They are loaded over the data input while a load input is held. Each pointer crosses into the other clock domain as a Gray code through a two-flop synchronizer. An asynchronous active-low reset clears the pointers, restores the offsets and returns every flag to its idle value.

Top module: `dcfifo_pf`

## Requirements
- R1: A write is accepted on a rising write-clock edge when wr_en_n=0, wr_en=1, load=0 and full=0. Words leave the buffer in the order they were accepted.
- R2: A read is accepted on a rising read-clock edge when rd_en_n=0, rd_en=1 and empty=0. The accepted word appears on dout just after that same edge and holds until the next accepted read.
- R3: full rises just after the edge that accepts the DEPTH-th stored word. A write attempted while full=1 is dropped and is never read out.
- R4: A read attempted while empty=1 leaves dout and the read position unchanged.
- R5: After a write into an empty buffer, with a common clock, empty stays 1 at the first and second falling edges after the write edge. It is 0 at the third falling edge, which follows the second rising read edge after the write.
- R6: almost_empty is 1 when the stored count is at most the empty offset. almost_full is 1 when the count plus the full offset is at least DEPTH. With offsets not loaded, both offsets are 7.
- R7: With load=1, each write-enabled edge copies din into one offset register and writes nothing to the array. The edges alternate between the empty offset and the full offset, starting with the empty offset after reset and wrapping around.
- R8: While rst_n=0, empty=1, almost_empty=1, full=0 and almost_full=0, and dout reads 0. On release, both pointers are cleared and both offsets are 7.
- R9: With oe=0, dout is high impedance and reads still advance the read position. With oe=1, dout shows the most recently read word.
- R10: Each clock-domain crossing carries a Gray-coded pointer, which changes by at most one bit per edge, through two flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both sides |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en | input | 1 | Write enable, active high |
| load | input | 1 | Selects offset loading instead of array writes |
| din | input | DW | Write data, or offset value while loading |
| rd_en_n | input | 1 | Read enable, active low |
| rd_en | input | 1 | Read enable, active high |
| oe | input | 1 | Output drive enable, high drives dout |
| dout | output | DW | Registered read data, high impedance when oe=0 |
| empty | output | 1 | No words held (read domain) |
| almost_empty | output | 1 | Count at or below empty offset (read domain) |
| almost_full | output | 1 | Count within full offset of DEPTH (write domain) |
| full | output | 1 | DEPTH words held (write domain) |

## Verification
The bench fills the buffer one word at a time from empty to full, then drains it back to empty. After each step it checks all four flags against a count it keeps itself. This catches a threshold compare that is off by one, which would move almost_empty or almost_full one word early or late. The fill and drain run once with the default offsets and once after a load sequence that wraps past the full offset, so a design whose offset selector does not alternate ends with the wrong thresholds.

Writes while full and reads while empty are attempted, and the data then read back is compared. A design that let either one through would return a stray word, or would skip a word and stay misaligned. Further checks look at the exact falling edge where empty drops after a write, at reads with the output disabled, and at a reset in mid-run. A synchronizer with a stage missing, a read pointer gated by oe, or offsets that survive reset would each be seen there.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    localparam int unsigned DFLT_OFS = 7;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)  rdata_q <= '0;
        else if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
    import dcfifo_pkg::*;
#(
    parameter int AW = 8,
    parameter int OW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  logic          load,
    input  logic [OW-1:0] din,
    input  logic [AW:0]   rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [OW-1:0] ae_off,
    output logic          full,
    output logic          almost_full
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        ofs_sel_e      sel;
        logic [OW-1:0] ae;
        logic [OW-1:0] af;
    } wst_t;

    wst_t          st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] used;
    logic          put;
    logic          ld;

    always_comb begin
        rbin[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin[i] = rbin[i+1] ^ rgray_s[i];
        end
        used        = st_q.bin - rbin;
        full        = (used == PW'(DEPTH));
        almost_full = (32'(used) + 32'(st_q.af)) >= 32'(DEPTH);
        ld          = wr_ok & load;
        put         = wr_ok & ~load & ~full;

        st_d = st_q;
        if (put) begin
            st_d.bin  = st_q.bin + PW'(1);
            st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        end
        if (ld) begin
            if (st_q.sel == SEL_AE) begin
                st_d.ae  = din;
                st_d.sel = SEL_AF;
            end else begin
                st_d.af  = din;
                st_d.sel = SEL_AE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bin: '0, gray: '0, sel: SEL_AE,
                      ae: OW'(DFLT_OFS), af: OW'(DFLT_OFS)};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we = put;
    assign waddr  = st_q.bin[AW-1:0];
    assign wgray  = st_q.gray;
    assign ae_off = st_q.ae;
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side #(
    parameter int AW = 8,
    parameter int OW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_ok,
    input  logic [AW:0]   wgray_s,
    input  logic [OW-1:0] ae_off,
    output logic          rd_fire,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rst_t;

    rst_t          st_d, st_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] avail;
    logic          take;

    always_comb begin
        wbin[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_s[i];
        end
        avail        = wbin - st_q.bin;
        empty        = (avail == '0);
        almost_empty = 32'(avail) <= 32'(ae_off);
        take         = rd_ok & ~empty;

        st_d = st_q;
        if (take) begin
            st_d.bin  = st_q.bin + PW'(1);
            st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_fire = take;
    assign raddr   = st_q.bin[AW-1:0];
    assign rgray   = st_q.gray;
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf #(
    parameter int DW    = 9,
    parameter int DEPTH = 256
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          wr_en,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          rd_en_n,
    input  logic          rd_en,
    input  logic          oe,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          almost_empty,
    output logic          almost_full,
    output logic          full
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_ok;
    logic          rd_ok;
    logic          mem_we;
    logic          rd_fire;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [AW:0]   wgray;
    logic [AW:0]   rgray;
    logic [AW:0]   wgray_s;
    logic [AW:0]   rgray_s;
    logic [DW-1:0] ae_off;
    logic [DW-1:0] dout_q;

    assign wr_ok = ~wr_en_n & wr_en;
    assign rd_ok = ~rd_en_n & rd_en;

    dcfifo_wr_side #(.AW(AW), .OW(DW)) u_wr (
        .clk         (wr_clk),
        .rst_n       (rst_n),
        .wr_ok       (wr_ok),
        .load        (load),
        .din         (din),
        .rgray_s     (rgray_s),
        .mem_we      (mem_we),
        .waddr       (waddr),
        .wgray       (wgray),
        .ae_off      (ae_off),
        .full        (full),
        .almost_full (almost_full)
    );

    dcfifo_rd_side #(.AW(AW), .OW(DW)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .rd_ok        (rd_ok),
        .wgray_s      (wgray_s),
        .ae_off       (ae_off),
        .rd_fire      (rd_fire),
        .raddr        (raddr),
        .rgray        (rgray),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    dcfifo_sync #(.W(AW + 1)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    dcfifo_sync #(.W(AW + 1)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    dcfifo_ram #(.AW(AW), .DW(DW)) u_ram (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (waddr),
        .wdata  (din),
        .rd_clk (rd_clk),
        .rst_n  (rst_n),
        .re     (rd_fire),
        .raddr  (raddr),
        .rdata  (dout_q)
    );

    assign dout = oe ? dout_q : {DW{1'bz}};
endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_ok,
    input logic          rd_ok,
    input logic          load,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rgray,
    input logic [DW-1:0] dout_q,
    input logic          empty,
    input logic          almost_empty,
    input logic          full,
    input logic          almost_full
);
    a_r3_no_write_when_full: assert property (
        @(posedge wr_clk) disable iff (!rst_n)
        (full && wr_ok && !load) |=> $stable(wgray));

    a_r7_load_no_write: assert property (
        @(posedge wr_clk) disable iff (!rst_n)
        (wr_ok && load) |=> $stable(wgray));

    a_r4_no_read_when_empty: assert property (
        @(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_ok) |=> ($stable(rgray) && $stable(dout_q)));

    a_r2_read_advances: assert property (
        @(posedge rd_clk) disable iff (!rst_n)
        (rd_ok && !empty) |=> (rgray != $past(rgray)));

    a_r10_wgray_one_bit: assert property (
        @(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    a_r10_rgray_one_bit: assert property (
        @(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    a_r6_empty_has_ae: assert property (
        @(posedge rd_clk) disable iff (!rst_n)
        empty |-> almost_empty);

    a_r6_full_has_af: assert property (
        @(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full);
endmodule

bind dcfifo_pf dcfifo_chk #(.AW(AW), .DW(DW)) u_chk (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .rst_n        (rst_n),
    .wr_ok        (wr_ok),
    .rd_ok        (rd_ok),
    .load         (load),
    .wgray        (wgray),
    .rgray        (rgray),
    .dout_q       (dout_q),
    .empty        (empty),
    .almost_empty (almost_empty),
    .full         (full),
    .almost_full  (almost_full)
);

// File: tb/sim_dcfifo_pf.sv
`timescale 1ns/1ps
module sim_dcfifo_pf;
    localparam int DW    = 9;
    localparam int DEPTH = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en_n, wr_en, load, rd_en_n, rd_en, oe;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          empty, almost_empty, almost_full, full;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dcfifo_pf #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_en_n(wr_en_n), .wr_en(wr_en), .load(load), .din(din),
        .rd_en_n(rd_en_n), .rd_en(rd_en), .oe(oe), .dout(dout),
        .empty(empty), .almost_empty(almost_empty),
        .almost_full(almost_full), .full(full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word(input int i);
        return DW'((i * 37 + 11) % 509 + 1);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge clk);
        wr_en_n = 1'b0; wr_en = 1'b1; din = v;
        @(negedge clk);
        wr_en_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en_n = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        rd_en_n = 1'b1; rd_en = 1'b0;
    endtask

    task automatic flags(input int c, input int aeo, input int afo);
        chk("R6 empty",        32'(empty),        32'(c == 0));
        chk("R6 almost_empty", 32'(almost_empty), 32'(c <= aeo));
        chk("R6 almost_full",  32'(almost_full),  32'(c + afo >= DEPTH));
        chk("R3 full",         32'(full),         32'(c == DEPTH));
    endtask

    task automatic sweep(input int aeo, input int afo);
        for (int i = 0; i < DEPTH; i++) begin
            push(word(i));
            if (i == DEPTH - 2) chk("R3 not yet full", 32'(full), 32'd0);
            if (i == DEPTH - 1) chk("R3 full same edge", 32'(full), 32'd1);
            idle(2);
            flags(i + 1, aeo, afo);
        end
        push(9'h1AA);
        idle(2);
        chk("R3 stays full after dropped write", 32'(full), 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            pop();
            chk("R1 R2 order", 32'(dout), 32'(word(i)));
            idle(2);
            flags(DEPTH - 1 - i, aeo, afo);
        end
        pop();
        chk("R4 dout holds on empty read", 32'(dout), 32'(word(DEPTH - 1)));
        chk("R4 still empty", 32'(empty), 32'd1);
    endtask

    initial begin
        rst_n = 1'b0; wr_en_n = 1'b1; wr_en = 1'b0; load = 1'b0;
        rd_en_n = 1'b1; rd_en = 1'b0; oe = 1'b1; din = '0;
        idle(3);
        chk("R8 reset empty", 32'(empty), 32'd1);
        chk("R8 reset almost_empty", 32'(almost_empty), 32'd1);
        chk("R8 reset full", 32'(full), 32'd0);
        chk("R8 reset almost_full", 32'(almost_full), 32'd0);
        chk("R8 reset dout", 32'(dout), 32'd0);
        rst_n = 1'b1;
        idle(2);

        sweep(7, 7);

        push(9'h055);
        chk("R5 empty first falling edge", 32'(empty), 32'd1);
        idle(1);
        chk("R5 empty second falling edge", 32'(empty), 32'd1);
        idle(1);
        chk("R5 empty clears third falling edge", 32'(empty), 32'd0);
        pop();
        chk("R4 pointer unmoved by empty read", 32'(dout), 32'h055);
        idle(2);

        load = 1'b1;
        push(9'd5);
        push(9'd9);
        push(9'd20);
        push(9'd30);
        load = 1'b0;
        idle(2);
        chk("R7 load writes no word", 32'(empty), 32'd1);
        sweep(20, 30);

        for (int i = 0; i < 10; i++) push(word(i));
        idle(2);
        rst_n = 1'b0;
        idle(1);
        chk("R8 mid reset empty", 32'(empty), 32'd1);
        chk("R8 mid reset full", 32'(full), 32'd0);
        chk("R8 mid reset almost_empty", 32'(almost_empty), 32'd1);
        rst_n = 1'b1;
        idle(1);
        for (int i = 0; i < 9; i++) begin
            push(word(i));
            idle(2);
            chk("R8 offset restored to 7", 32'(almost_empty), 32'(i + 1 <= 7));
        end

        oe = 1'b0;
        pop();
        chk("R9 dout released with oe low", 32'(dout === word(0)), 32'd0);
        oe = 1'b1;
        #1;
        chk("R9 dout shows word read with oe low", 32'(dout), 32'(word(0)));
        pop();
        chk("R9 pointer advanced under oe low", 32'(dout), 32'(word(1)));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule